// File: doc/BRIEF.md
# Two-Entry Receive Holding Buffer

This block sits between the shift logic of a serial receiver and a register read port. Each time the shift logic finishes a character, it pulses a strobe with the character. The block holds that character in one of two entries. The front entry is always what the read port returns. The rear entry holds a second character that is waiting behind it. An explicit write pointer, not an occupancy counter, decides which entry the next character lands in.

Software sees a receive-ready flag whenever the front entry holds an unread character. Each read strobe takes one character. Consider the case where both entries are occupied and another character arrives. The rear character moves forward, the new character takes the rear slot, and the oldest character is discarded. A sticky overflow bit records the loss, and writing a 1 to it clears it. A receiver-enable input gates all storage. While the enable is low, the pointer returns to the front and both entries are marked empty.

Top module: `spi_rx_holdbuf`

## Requirements
- R1: After reset, `rx_ready` is 0, `ovf_flag` is 0 and `rd_data` is all zeros.
- R2: With the buffer empty and `rx_en` high, a character strobed on `char_vld` appears on `rd_data` with `rx_ready` high from the cycle after the strobe.
- R3: A read strobe while only the front entry is occupied drops `rx_ready` on the next cycle. The next character then lands in the front entry and appears on `rd_data`.
- R4: A second character that arrives before any read is stored behind the first. Successive reads then present the older character and then the newer one, and `rx_ready` stays high until both have been read.
- R5: A character that arrives while both entries are occupied, with no read in the same cycle, discards the oldest character. The former rear character moves to the front, the new character moves to the rear, and `ovf_flag` is set on the next cycle.
- R6: `ovf_flag` stays set until a cycle with `ovf_clr` high, and it reads 0 after that cycle. If a discard happens in the same cycle as the clear, the flag stays set.
- R7: While `rx_en` is low, arriving characters are not stored. From the cycle after `rx_en` is low, `rx_ready` is 0 and both entries count as empty.
- R8: When a read strobe and an arriving character share a cycle, the read is applied first and the character is placed afterwards. With one entry occupied, the new character becomes the front. With both occupied, no character is lost and `ovf_flag` is not set.
- R9: `rx_ready` equals the front entry's occupancy. The rear entry is never occupied while the front entry is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low empties the buffer and blocks storage |
| char_vld | input | 1 | One-cycle strobe: a completed character is on `char_in` |
| char_in | input | DATA_W | Completed received character |
| rd_stb | input | 1 | Read strobe from the register port; consumes the front character |
| ovf_clr | input | 1 | Write-1-to-clear strobe for the overflow bit |
| rd_data | output | DATA_W | Front entry contents |
| rx_ready | output | 1 | Front entry holds an unread character |
| ovf_flag | output | 1 | Sticky overflow: a character was discarded |

## Verification
The assertions assume that `char_vld`, `rd_stb` and `ovf_clr` are single-cycle strobes sampled at the clock edge. They also assume that a read strobe issued while `rx_ready` is low is harmless, so nothing beyond that is relied on. The stimulus drives every input half a cycle before the capturing edge. It sweeps all sequences of four cycles built from the four combinations of arrival and read. Each sequence starts from an empty buffer and runs with `rx_en` high, so every order of pointer moves, overwrites and coincident strobes is reached. Separate directed steps cover disable, overflow clearing and the reset state.

// File: rtl/rxhb_pkg.sv
package rxhb_pkg;
    typedef enum logic {
        PTR_FRONT = 1'b0,
        PTR_REAR  = 1'b1
    } wr_ptr_e;
endpackage

// File: rtl/rxhb_store.sv
module rxhb_store
    import rxhb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] front_o,
    output logic              front_v_o,
    output logic              rear_v_o,
    output logic              drop_o
);
    typedef struct packed {
        logic [DATA_W-1:0] front;
        logic [DATA_W-1:0] rear;
        logic              front_v;
        logic              rear_v;
        wr_ptr_e           ptr;
    } store_t;

    store_t st_d, st_q;
    logic   drop_d;

    always_comb begin
        st_d   = st_q;
        drop_d = 1'b0;
        if (!en_i) begin
            st_d.front_v = 1'b0;
            st_d.rear_v  = 1'b0;
            st_d.ptr     = PTR_FRONT;
        end else begin
            // read is applied first
            if (rd_i && st_d.front_v) begin
                if (st_d.rear_v) begin
                    st_d.front  = st_d.rear;
                    st_d.rear_v = 1'b0;
                end else begin
                    st_d.front_v = 1'b0;
                    st_d.ptr     = PTR_FRONT;
                end
            end
            // then the arriving character is placed
            if (wr_i) begin
                case (st_d.ptr)
                    PTR_FRONT: begin
                        st_d.front   = wdata_i;
                        st_d.front_v = 1'b1;
                        st_d.ptr     = PTR_REAR;
                    end
                    default: begin
                        if (!st_d.rear_v) begin
                            st_d.rear   = wdata_i;
                            st_d.rear_v = 1'b1;
                        end else begin
                            st_d.front = st_d.rear;
                            st_d.rear  = wdata_i;
                            drop_d     = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{front: '0, rear: '0, front_v: 1'b0, rear_v: 1'b0, ptr: PTR_FRONT};
        end else begin
            st_q <= st_d;
        end
    end

    assign front_o   = st_q.front;
    assign front_v_o = st_q.front_v;
    assign rear_v_o  = st_q.rear_v;
    assign drop_o    = drop_d;

    // R9: pointer sits on the rear exactly when the front is occupied
    always_comb begin
        if (rst_n) begin
            p_ptr_tracks_front_r9: assert ((st_q.ptr == PTR_REAR) == st_q.front_v);
        end
    end

    // R4: a waiting rear character always has a front character ahead of it
    always_comb begin
        if (rst_n) begin
            p_rear_behind_front_r4: assert (!st_q.rear_v || st_q.front_v);
        end
    end
endmodule

// File: rtl/rxhb_sticky.sv
module rxhb_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    p_clear_works_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
endmodule

// File: rtl/spi_rx_holdbuf.sv
module spi_rx_holdbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              char_vld,
    input  logic [DATA_W-1:0] char_in,
    input  logic              rd_stb,
    input  logic              ovf_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_ready,
    output logic              ovf_flag
);
    logic front_v, rear_v, drop;

    rxhb_store #(.DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (rx_en),
        .wr_i     (char_vld),
        .wdata_i  (char_in),
        .rd_i     (rd_stb),
        .front_o  (rd_data),
        .front_v_o(front_v),
        .rear_v_o (rear_v),
        .drop_o   (drop)
    );

    rxhb_sticky u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (drop),
        .clr_i (ovf_clr),
        .flag_o(ovf_flag)
    );

    assign rx_ready = front_v;

    p_first_char_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && char_vld && !front_v) |=> (rx_ready && rd_data == $past(char_in)));
    p_single_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rd_stb && front_v && !rear_v && !char_vld) |=> !rx_ready);
    p_overwrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && char_vld && front_v && rear_v && !rd_stb) |=> (ovf_flag && rx_ready));
    p_disable_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_ready);
    p_coincident_no_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && char_vld && rd_stb) |-> !drop);
endmodule

// File: tb/spi_rx_holdbuf_tb.sv
module spi_rx_holdbuf_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_en = 1'b0, char_vld = 1'b0, rd_stb = 1'b0, ovf_clr = 1'b0;
    logic [W-1:0] char_in = '0;
    logic [W-1:0] rd_data;
    logic         rx_ready, ovf_flag;

    int n_chk = 0, n_bad = 0;
    // reference: queue of up to two characters
    logic [W-1:0] mq [2];
    int           mn = 0;
    logic         movf = 1'b0;
    logic [W-1:0] seq_val = 8'h01;

    always #10 clk = ~clk;

    spi_rx_holdbuf #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .char_vld(char_vld),
        .char_in(char_in), .rd_stb(rd_stb), .ovf_clr(ovf_clr),
        .rd_data(rd_data), .rx_ready(rx_ready), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, update model, sample after the edge
    task automatic step(input logic en, input logic v, input logic [W-1:0] d,
                        input logic r, input logic c);
        logic drop;
        @(negedge clk);
        rx_en = en; char_vld = v; char_in = d; rd_stb = r; ovf_clr = c;
        drop = 1'b0;
        if (!en) mn = 0;
        else begin
            if (r && mn > 0) begin mq[0] = mq[1]; mn--; end
            if (v) begin
                if (mn < 2) begin mq[mn] = d; mn++; end
                else begin mq[0] = mq[1]; mq[1] = d; drop = 1'b1; end
            end
        end
        if (c) movf = 1'b0;
        if (drop) movf = 1'b1;
        @(posedge clk);
        #2;
        char_vld = 1'b0; rd_stb = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic cmp(input string tag);
        chk({tag, " ready"}, {31'b0, rx_ready}, {31'b0, mn > 0});
        chk({tag, " ovf"},   {31'b0, ovf_flag}, {31'b0, movf});
        if (mn > 0) chk({tag, " data"}, {24'b0, rd_data}, {24'b0, mq[0]});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #35;
        // R1 reset state
        chk("R1 ready", {31'b0, rx_ready}, 0);
        chk("R1 ovf",   {31'b0, ovf_flag}, 0);
        chk("R1 data",  {24'b0, rd_data}, 0);
        rst_n = 1'b1;
        step(1, 0, 0, 0, 0);
        // R2 first arrival
        step(1, 1, 8'h11, 0, 0); cmp("R2");
        chk("R2 data", {24'b0, rd_data}, 32'h11);
        // R3 single read then pointer back to front
        step(1, 0, 0, 1, 0); chk("R3 ready", {31'b0, rx_ready}, 0);
        step(1, 1, 8'h22, 0, 0); chk("R3 data", {24'b0, rd_data}, 32'h22);
        step(1, 0, 0, 1, 0);
        // R4 two queued, read in order
        step(1, 1, 8'h33, 0, 0); step(1, 1, 8'h44, 0, 0);
        chk("R4 first", {24'b0, rd_data}, 32'h33);
        step(1, 0, 0, 1, 0);
        chk("R4 second", {24'b0, rd_data}, 32'h44); chk("R4 ready", {31'b0, rx_ready}, 1);
        step(1, 0, 0, 1, 0); chk("R4 empty", {31'b0, rx_ready}, 0);
        // R5 overwrite of oldest
        step(1, 1, 8'h55, 0, 0); step(1, 1, 8'h66, 0, 0); step(1, 1, 8'h77, 0, 0);
        chk("R5 ovf", {31'b0, ovf_flag}, 1); chk("R5 front", {24'b0, rd_data}, 32'h66);
        step(1, 0, 0, 1, 0); chk("R5 rear", {24'b0, rd_data}, 32'h77);
        // R6 clear, then set-beats-clear
        step(1, 0, 0, 0, 1); chk("R6 cleared", {31'b0, ovf_flag}, 0);
        step(1, 1, 8'h88, 0, 0);
        step(1, 1, 8'h99, 0, 1); chk("R6 set wins", {31'b0, ovf_flag}, 1);
        chk("R6 data", {24'b0, rd_data}, 32'h88);
        // R7 disable empties and blocks
        step(0, 0, 0, 0, 1); chk("R7 empty", {31'b0, rx_ready}, 0);
        step(0, 1, 8'hAA, 0, 0); chk("R7 blocked", {31'b0, rx_ready}, 0);
        step(1, 0, 0, 0, 0); chk("R7 still empty", {31'b0, rx_ready}, 0);
        // R8 coincident read and arrival
        step(1, 1, 8'hB1, 0, 0);
        step(1, 1, 8'hB2, 1, 0); chk("R8 one", {24'b0, rd_data}, 32'hB2);
        step(1, 1, 8'hB3, 0, 0);
        step(1, 1, 8'hB4, 1, 0); chk("R8 full ovf", {31'b0, ovf_flag}, 0);
        chk("R8 full data", {24'b0, rd_data}, 32'hB3);
        step(1, 0, 0, 1, 0); chk("R8 rear", {24'b0, rd_data}, 32'hB4);
        // R9 sweep: every 4-step sequence of {arrive, read}
        for (int s = 0; s < 256; s++) begin
            step(0, 0, 0, 0, 1);
            cmp("R9 start");
            for (int k = 0; k < 4; k++) begin
                int op = (s >> (2 * k)) & 3;
                seq_val = seq_val + 8'd1;
                step(1, op[0], seq_val, op[1], 0);
                cmp("R9 sweep");
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule